// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps an asynchronous DRAM alive. After reset it waits out the power-up pause. It then runs a burst of CAS-before-RAS refresh cycles and raises a status flag when the memory is ready for accesses. From then on it issues one refresh per refresh interval. All timing is counted in cycles of the system clock, and every interval and pulse width is a parameter.

The sequencer shares the DRAM strobes with a host-access controller. When it needs the memory it raises a bus request. It drives the row strobe and the byte-lane column strobes only while the controller grants the bus. If a refresh waits longer than one interval for the grant, an overdue flag is raised.

A power manager can ask the memory to enter its self-refresh state and later to leave it. The sequencer wraps each self-refresh period with the required refreshes:

- it runs one normal refresh immediately before entry;
- it keeps the row strobe low for at least the minimum self-refresh time, so no shallow low window can occur;
- it applies the long precharge on exit;
- it runs one refresh right after exit.

It refuses a new entry until a full set of row refreshes has run since the last exit.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, rasN and every casN lane are 1, and refReq, initDone, inSelfRefresh and refOverdue are 0.
- R2: After reset is released, refReq stays 0 for at least INIT_PAUSE_CYC clock cycles, and no strobe goes low in that time.
- R3: After the pause, exactly INIT_REFS refresh cycles run back to back. initDone then rises and stays 1 until reset.
- R4: Every refresh is CAS-before-RAS: all casN lanes go low together at least CSR_CYC cycles before rasN falls and stay low while rasN is low. In a normal refresh rasN is low for exactly RAS_LOW_CYC cycles.
- R5: rasN stays high for at least RP_CYC cycles between any two low windows.
- R6: A strobe is low only while refReq is 1 and busGrant is 1. While refReq waits without a grant, all strobes stay high.
- R7: Once initDone is 1, one normal refresh starts every REF_INTERVAL_CYC cycles when the grant arrives with a constant delay.
- R8: refOverdue rises once refReq has waited REF_INTERVAL_CYC cycles without a grant. It is 0 while waits are short, and it clears within a few cycles of the grant.
- R9: An accepted srEnterCmd pulse produces one normal refresh. That refresh is followed, after exactly RP_CYC+CSR_CYC high cycles, by a CAS-before-RAS entry during which rasN stays low and inSelfRefresh is 1.
- R10: A self-refresh low window lasts at least SR_MIN_CYC cycles even when exit is asked for early. An exit request made after that minimum ends the window within a few cycles. Every rasN low window is either exactly RAS_LOW_CYC or at least SR_MIN_CYC cycles long.
- R11: After a self-refresh window, rasN stays high for exactly SR_RP_CYC+CSR_CYC cycles, and a normal refresh follows.
- R12: Commands that may not act are ignored. srEnterCmd has no effect before initDone, or before ROWS normal refreshes have completed since the last exit. srExitCmd has no effect outside a self-refresh window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busGrant | input | 1 | The host controller has released the DRAM strobes to the sequencer |
| srEnterCmd | input | 1 | One-cycle request to enter self-refresh |
| srExitCmd | input | 1 | One-cycle request to leave self-refresh |
| refReq | output | 1 | The sequencer needs, or holds, the DRAM strobes |
| rasN | output | 1 | Row strobe, active low |
| casN | output | CAS_LANES | Byte-lane column strobes, active low, always driven together |
| initDone | output | 1 | Power-up sequence complete; accesses may start |
| inSelfRefresh | output | 1 | The DRAM is held in self-refresh |
| refOverdue | output | 1 | A pending refresh has waited one interval or more for the grant |

## Verification
The strobes are driven under several host patterns:

- An always-free host gives a constant grant delay, so refresh spacing can be measured exactly.
- A host that stays busy past one interval separates the overdue flag from an ordinary short wait.
- Alternating busy and free bursts of random length show that strobe shape and refresh rate do not depend on when grants come.

Self-refresh is tried three ways. One case has a stale exit command issued before entry, which must not end the window. One case has an early exit, which must not shorten it. One case has an entry command issued too soon after an exit, which must be refused until a full set of row refreshes has run.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    LD_NONE, LD_CSR, LD_RASLO, LD_RP, LD_SRMIN, LD_SRRP
  } loadSel_e;

  typedef enum logic [2:0] {
    ST_PAUSE, ST_IDLE, ST_REQ, ST_CSU, ST_RLO, ST_PRE, ST_SRLO, ST_SRPRE
  } state_e;

  typedef enum logic [2:0] {
    JOB_INIT, JOB_PERIODIC, JOB_SR_PRE, JOB_SR_HOLD, JOB_SR_POST
  } job_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    loadSel_e load;
    logic     tickEn;
    logic     clrDue;
    logic     waiting;
    logic     incInit;
    logic     incRows;
    logic     clrRows;
  } tmrStrobe_t;

  function automatic int unsigned maxOf(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ref_timer_dp.sv
module ref_timer_dp
  import dram_ref_pkg::*;
#(
  parameter int unsigned INIT_PAUSE_CYC   = 200,
  parameter int unsigned INIT_REFS        = 8,
  parameter int unsigned REF_INTERVAL_CYC = 100,
  parameter int unsigned CSR_CYC          = 2,
  parameter int unsigned RAS_LOW_CYC      = 6,
  parameter int unsigned RP_CYC           = 4,
  parameter int unsigned SR_MIN_CYC       = 300,
  parameter int unsigned SR_RP_CYC        = 12,
  parameter int unsigned ROWS             = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  tmrStrobe_t strb,
  output logic       phaseZero,
  output logic       duePend,
  output logic       lastInit,
  output logic       rowsFull,
  output logic       overdue
);

  localparam int unsigned PH_MAX = maxOf(maxOf(maxOf(INIT_PAUSE_CYC, SR_MIN_CYC),
                                               maxOf(SR_RP_CYC, RAS_LOW_CYC)),
                                         maxOf(CSR_CYC, RP_CYC));
  localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
  localparam int unsigned IV_W   = $clog2(REF_INTERVAL_CYC + 1);
  localparam int unsigned ROW_W  = $clog2(ROWS + 1);
  localparam int unsigned INIT_W = $clog2(INIT_REFS + 1);

  logic [PH_W-1:0]   phaseCnt;
  logic [IV_W-1:0]   ivCnt;
  logic [IV_W-1:0]   waitCnt;
  logic [ROW_W-1:0]  rowsCnt;
  logic [INIT_W-1:0] initCnt;
  logic              ivWrap;

  // shared phase timer: loaded with a length-1, counts down and holds at zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseCnt <= PH_W'(INIT_PAUSE_CYC - 1);
    else begin
      case (strb.load)
        LD_CSR:   phaseCnt <= PH_W'(CSR_CYC - 1);
        LD_RASLO: phaseCnt <= PH_W'(RAS_LOW_CYC - 1);
        LD_RP:    phaseCnt <= PH_W'(RP_CYC - 1);
        LD_SRMIN: phaseCnt <= PH_W'(SR_MIN_CYC - 1);
        LD_SRRP:  phaseCnt <= PH_W'(SR_RP_CYC - 1);
        default:  if (phaseCnt != '0) phaseCnt <= phaseCnt - 1'b1;
      endcase
    end
  end
  assign phaseZero = (phaseCnt == '0);

  // free-running refresh interval timer
  assign ivWrap = strb.tickEn && (ivCnt == IV_W'(REF_INTERVAL_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ivCnt <= '0;
    else if (!strb.tickEn || ivWrap) ivCnt <= '0;
    else ivCnt <= ivCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) duePend <= 1'b0;
    else if (ivWrap) duePend <= 1'b1;
    else if (strb.clrDue) duePend <= 1'b0;
  end

  // grant wait, saturating at one interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitCnt <= '0;
    else if (!strb.waiting) waitCnt <= '0;
    else if (waitCnt != IV_W'(REF_INTERVAL_CYC)) waitCnt <= waitCnt + 1'b1;
  end
  assign overdue = (waitCnt == IV_W'(REF_INTERVAL_CYC));

  // refreshes since the last self-refresh exit; starts saturated
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rowsCnt <= ROW_W'(ROWS);
    else if (strb.clrRows) rowsCnt <= '0;
    else if (strb.incRows && rowsCnt != ROW_W'(ROWS)) rowsCnt <= rowsCnt + 1'b1;
  end
  assign rowsFull = (rowsCnt == ROW_W'(ROWS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initCnt <= '0;
    else if (strb.incInit && initCnt != INIT_W'(INIT_REFS)) initCnt <= initCnt + 1'b1;
  end
  assign lastInit = (initCnt == INIT_W'(INIT_REFS - 1));

endmodule

// File: rtl/ref_seq_ctrl.sv
module ref_seq_ctrl
  import dram_ref_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busGrant,
  input  logic       srEnterCmd,
  input  logic       srExitCmd,
  input  logic       phaseZero,
  input  logic       duePend,
  input  logic       lastInit,
  input  logic       rowsFull,
  output tmrStrobe_t strb,
  output logic       refReq,
  output logic       rasN,
  output logic       casN,
  output logic       initDone,
  output logic       inSelfRefresh
);

  state_e state, nState;
  job_e   job, nJob;
  logic   nInitDone;
  logic   enterPend, exitPend;
  logic   srBusy;

  assign srBusy = enterPend ||
                  ((job == JOB_SR_PRE || job == JOB_SR_HOLD || job == JOB_SR_POST) &&
                   state != ST_IDLE);

  always_comb begin
    nState    = state;
    nJob      = job;
    nInitDone = initDone;
    strb      = '0;
    strb.tickEn = initDone;
    case (state)
      ST_PAUSE: if (phaseZero) begin
        nState = ST_REQ;
        nJob   = JOB_INIT;
      end
      ST_IDLE: begin
        if (enterPend) begin
          nState = ST_REQ;
          nJob   = JOB_SR_PRE;
        end else if (duePend) begin
          nState = ST_REQ;
          nJob   = JOB_PERIODIC;
        end
      end
      ST_REQ: begin
        strb.waiting = !busGrant;
        if (busGrant) begin
          nState      = ST_CSU;
          strb.load   = LD_CSR;
          strb.clrDue = 1'b1;
        end
      end
      ST_CSU: if (phaseZero) begin
        if (job == JOB_SR_HOLD) begin
          nState    = ST_SRLO;
          strb.load = LD_SRMIN;
        end else begin
          nState    = ST_RLO;
          strb.load = LD_RASLO;
        end
      end
      ST_RLO: if (phaseZero) begin
        nState       = ST_PRE;
        strb.load    = LD_RP;
        strb.incRows = 1'b1;
      end
      ST_PRE: if (phaseZero) begin
        case (job)
          JOB_INIT: begin
            strb.incInit = 1'b1;
            if (lastInit) begin
              nInitDone = 1'b1;
              nState    = ST_IDLE;
            end else begin
              nState      = ST_CSU;
              strb.load   = LD_CSR;
              strb.clrDue = 1'b1;
            end
          end
          JOB_SR_PRE: begin
            nState      = ST_CSU;
            nJob        = JOB_SR_HOLD;
            strb.load   = LD_CSR;
            strb.clrDue = 1'b1;
          end
          default: nState = ST_IDLE;
        endcase
      end
      ST_SRLO: if (phaseZero && exitPend) begin
        nState       = ST_SRPRE;
        strb.load    = LD_SRRP;
        strb.clrRows = 1'b1;
      end
      ST_SRPRE: if (phaseZero) begin
        nState      = ST_CSU;
        nJob        = JOB_SR_POST;
        strb.load   = LD_CSR;
        strb.clrDue = 1'b1;
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_PAUSE;
      job      <= JOB_INIT;
      initDone <= 1'b0;
    end else begin
      state    <= nState;
      job      <= nJob;
      initDone <= nInitDone;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enterPend <= 1'b0;
    else if (state == ST_IDLE && enterPend) enterPend <= 1'b0;
    else if (srEnterCmd && initDone && rowsFull && !srBusy) enterPend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) exitPend <= 1'b0;
    else if (state != ST_SRLO) exitPend <= 1'b0;
    else if (srExitCmd) exitPend <= 1'b1;
  end

  // strobes registered from the next state: glitch-free pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasN          <= 1'b1;
      casN          <= 1'b1;
      refReq        <= 1'b0;
      inSelfRefresh <= 1'b0;
    end else begin
      rasN          <= !(nState == ST_RLO || nState == ST_SRLO);
      casN          <= !(nState == ST_CSU || nState == ST_RLO || nState == ST_SRLO);
      refReq        <= !(nState == ST_PAUSE || nState == ST_IDLE);
      inSelfRefresh <= (nState == ST_SRLO);
    end
  end

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int unsigned INIT_PAUSE_CYC   = 200,
  parameter int unsigned INIT_REFS        = 8,
  parameter int unsigned REF_INTERVAL_CYC = 100,
  parameter int unsigned CSR_CYC          = 2,
  parameter int unsigned RAS_LOW_CYC      = 6,
  parameter int unsigned RP_CYC           = 4,
  parameter int unsigned SR_MIN_CYC       = 300,
  parameter int unsigned SR_RP_CYC        = 12,
  parameter int unsigned ROWS             = 512,
  parameter int unsigned CAS_LANES        = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busGrant,
  input  logic                 srEnterCmd,
  input  logic                 srExitCmd,
  output logic                 refReq,
  output logic                 rasN,
  output logic [CAS_LANES-1:0] casN,
  output logic                 initDone,
  output logic                 inSelfRefresh,
  output logic                 refOverdue
);

  tmrStrobe_t strb;
  logic phaseZero, duePend, lastInit, rowsFull, casOne;

  ref_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busGrant(busGrant),
    .srEnterCmd(srEnterCmd), .srExitCmd(srExitCmd),
    .phaseZero(phaseZero), .duePend(duePend), .lastInit(lastInit), .rowsFull(rowsFull),
    .strb(strb), .refReq(refReq), .rasN(rasN), .casN(casOne),
    .initDone(initDone), .inSelfRefresh(inSelfRefresh)
  );

  ref_timer_dp #(
    .INIT_PAUSE_CYC(INIT_PAUSE_CYC), .INIT_REFS(INIT_REFS),
    .REF_INTERVAL_CYC(REF_INTERVAL_CYC), .CSR_CYC(CSR_CYC),
    .RAS_LOW_CYC(RAS_LOW_CYC), .RP_CYC(RP_CYC), .SR_MIN_CYC(SR_MIN_CYC),
    .SR_RP_CYC(SR_RP_CYC), .ROWS(ROWS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .phaseZero(phaseZero), .duePend(duePend), .lastInit(lastInit),
    .rowsFull(rowsFull), .overdue(refOverdue)
  );

  // either byte lane alone selects the refresh; both lanes move together
  assign casN = {CAS_LANES{casOne}};

endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int unsigned RAS_LOW_CYC = 6,
  parameter int unsigned SR_MIN_CYC  = 300,
  parameter int unsigned CAS_LANES   = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busGrant,
  input logic                 refReq,
  input logic                 rasN,
  input logic [CAS_LANES-1:0] casN,
  input logic                 initDone,
  input logic                 inSelfRefresh
);

  localparam int unsigned LW = $clog2(SR_MIN_CYC + 1);
  logic [LW-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= '0;
    else if (rasN) lowCnt <= '0;
    else if (lowCnt != LW'(SR_MIN_CYC)) lowCnt <= lowCnt + 1'b1;
  end

  // R4: column strobes lead the row strobe fall
  p_cas_lead_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (casN == '0) && ($past(casN) == '0));

  // R4: column strobes held for the whole row-low window
  p_cas_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> (casN == '0));

  // R6: strobes only move under grant
  p_grant_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN || casN != {CAS_LANES{1'b1}}) |-> (busGrant && refReq));

  // R10: no low window between a normal pulse and the self-refresh minimum
  p_no_shallow_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (lowCnt == LW'(RAS_LOW_CYC) || lowCnt == LW'(SR_MIN_CYC)));

  // R3: ready flag is sticky
  p_init_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // R12: self-refresh only after initialization
  p_sr_after_init_r12: assert property (@(posedge clk) disable iff (!rstN)
    inSelfRefresh |-> initDone);

endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .RAS_LOW_CYC(RAS_LOW_CYC), .SR_MIN_CYC(SR_MIN_CYC), .CAS_LANES(CAS_LANES)
) u_chk (
  .clk(clk), .rstN(rstN), .busGrant(busGrant), .refReq(refReq), .rasN(rasN),
  .casN(casN), .initDone(initDone), .inSelfRefresh(inSelfRefresh)
);

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;

  localparam int PAUSE = 200, NINIT = 8, IV = 100, CSR = 2, RLOW = 6, RP = 4;
  localparam int SRMIN = 300, SRRP = 12, ROWS = 512, LANES = 2;

  logic clk = 1'b0, rstN = 1'b0, busGrant = 1'b0, srEnterCmd = 1'b0, srExitCmd = 1'b0;
  logic refReq, rasN, initDone, inSelfRefresh, refOverdue;
  logic [LANES-1:0] casN;
  logic hostFree = 1'b1;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  dram_refresh_sched #(
    .INIT_PAUSE_CYC(PAUSE), .INIT_REFS(NINIT), .REF_INTERVAL_CYC(IV), .CSR_CYC(CSR),
    .RAS_LOW_CYC(RLOW), .RP_CYC(RP), .SR_MIN_CYC(SRMIN), .SR_RP_CYC(SRRP),
    .ROWS(ROWS), .CAS_LANES(LANES)
  ) u0 (
    .clk(clk), .rstN(rstN), .busGrant(busGrant), .srEnterCmd(srEnterCmd),
    .srExitCmd(srExitCmd), .refReq(refReq), .rasN(rasN), .casN(casN),
    .initDone(initDone), .inSelfRefresh(inSelfRefresh), .refOverdue(refOverdue)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected normal refreshes in a window of w cycles
  function automatic int expRefs(input int w);
    return w / IV;
  endfunction

  // host controller model: grant held while the request stays up
  always @(negedge clk)
    if (!rstN) busGrant <= 1'b0;
    else busGrant <= refReq && (busGrant || hostFree);

  int cyc = 0;
  always @(posedge clk) if (rstN) cyc++;

  // strobe monitor
  int rasLowLen = 0, rasHighLen = 0, casLowLen = 0;
  int refCount = 0, srCount = 0, normFallCnt = 0, normFallCyc = 0, lastSrLen = 0;
  int firstReqCyc = -1;
  bit prevRas = 1, seenFall = 0, lastWasNormal = 0, lastWasSr = 0, sawSr = 0, sawOverdue = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (refReq && firstReqCyc < 0) firstReqCyc = cyc;
      if (inSelfRefresh) sawSr = 1;
      if (refOverdue) sawOverdue = 1;
      if (!rasN && prevRas) begin
        chk(casLowLen >= CSR, "R4 cas lead", casLowLen, CSR);
        if (seenFall) chk(rasHighLen >= RP, "R5 precharge", rasHighLen, RP);
        if (inSelfRefresh)
          chk(lastWasNormal && rasHighLen == RP + CSR, "R9 entry bracket", rasHighLen, RP + CSR);
        else begin
          normFallCnt++;
          normFallCyc = cyc;
        end
        if (lastWasSr)
          chk(!inSelfRefresh && rasHighLen == SRRP + CSR, "R11 exit precharge", rasHighLen, SRRP + CSR);
        lastWasSr = 0;
        seenFall = 1;
      end
      if (!rasN) chk(casN == '0, "R4 lanes held", int'(casN), 0);
      if (!rasN || casN != '1) chk(busGrant && refReq, "R6 grant", int'(busGrant), 1);
      if (rasN && !prevRas) begin
        if (rasLowLen == RLOW) begin
          refCount++;
          lastWasNormal = 1;
        end else begin
          chk(rasLowLen >= SRMIN, "R10 window length", rasLowLen, SRMIN);
          srCount++;
          lastSrLen = rasLowLen;
          lastWasSr = 1;
          lastWasNormal = 0;
        end
      end
      rasLowLen  = rasN ? 0 : rasLowLen + 1;
      rasHighLen = rasN ? rasHighLen + 1 : 0;
      casLowLen  = (casN == '0) ? casLowLen + 1 : 0;
      prevRas    = rasN;
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseEnter();
    @(negedge clk) srEnterCmd = 1'b1;
    @(negedge clk) srEnterCmd = 1'b0;
  endtask

  task automatic pulseExit();
    @(negedge clk) srExitCmd = 1'b1;
    @(negedge clk) srExitCmd = 1'b0;
  endtask

  task automatic randomHost(input int untilRefs);
    while (refCount < untilRefs) begin
      hostFree = 1'b0;
      waitCycles($urandom_range(1, 20));
      hostFree = 1'b1;
      waitCycles($urandom_range(1, 40));
    end
    hostFree = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int t1, t2, t3, n0, r0, s0, w0, c0;
    void'($urandom(32'd4711));
    waitCycles(3);
    chk(rasN && casN == '1 && !refReq, "R1 strobes in reset", int'(rasN), 1);
    chk(!initDone && !inSelfRefresh && !refOverdue, "R1 flags in reset", int'(initDone), 0);
    @(negedge clk) rstN = 1'b1;

    // R12: entry during the pause is ignored
    waitCycles(20);
    pulseEnter();

    while (!initDone) @(negedge clk);
    waitCycles(1);
    chk(firstReqCyc >= PAUSE, "R2 power-up pause", firstReqCyc, PAUSE);
    chk(refCount == NINIT, "R3 initial refresh count", refCount, NINIT);
    chk(!sawSr, "R12 entry before init ignored", int'(sawSr), 0);

    // R7: spacing with a constant grant delay
    n0 = normFallCnt;
    while (normFallCnt < n0 + 1) @(negedge clk);
    t1 = normFallCyc;
    while (normFallCnt < n0 + 2) @(negedge clk);
    t2 = normFallCyc;
    while (normFallCnt < n0 + 3) @(negedge clk);
    t3 = normFallCyc;
    chk(t2 - t1 == IV, "R7 interval a", t2 - t1, IV);
    chk(t3 - t2 == IV, "R7 interval b", t3 - t2, IV);
    chk(!sawOverdue, "R8 no overdue on prompt grant", int'(sawOverdue), 0);

    // R8: host keeps the bus past one interval
    while (refReq) @(negedge clk);
    hostFree = 1'b0;
    while (!refReq) @(negedge clk);
    waitCycles(IV / 2);
    chk(!refOverdue, "R8 short wait", int'(refOverdue), 0);
    chk(rasN && casN == '1, "R6 strobes idle without grant", int'(rasN), 1);
    waitCycles(IV / 2 + 10);
    chk(refOverdue, "R8 long wait", int'(refOverdue), 1);
    hostFree = 1'b1;
    waitCycles(6);
    chk(!refOverdue, "R8 cleared after grant", int'(refOverdue), 0);
    waitCycles(20);

    // R9/R12: stale exit, then entry; window must hold
    pulseExit();
    waitCycles(5);
    r0 = refCount;
    pulseEnter();
    while (!inSelfRefresh) @(negedge clk);
    waitCycles(1);
    chk(refCount == r0 + 1, "R9 refresh before entry", refCount, r0 + 1);
    waitCycles(SRMIN + 50);
    chk(!rasN && inSelfRefresh, "R12 stale exit ignored", int'(rasN), 0);
    pulseExit();
    while (inSelfRefresh) @(negedge clk);
    r0 = refCount;
    while (refCount < r0 + 1) @(negedge clk);
    waitCycles(2);
    chk(srCount == 1, "R11 one window then refresh", srCount, 1);

    // R12: re-entry too soon
    s0 = refCount;
    pulseEnter();
    waitCycles(3 * IV);
    chk(srCount == 1 && !inSelfRefresh, "R12 early re-entry refused", srCount, 1);

    // random host traffic until a full set has run since exit
    sawOverdue = 0;
    w0 = cyc;
    c0 = refCount;
    randomHost(s0 + ROWS + 1);
    waitCycles(2);
    chk(!sawOverdue, "R8 short random waits", int'(sawOverdue), 0);
    chk((refCount - c0) >= expRefs(cyc - w0) - 1 && (refCount - c0) <= expRefs(cyc - w0) + 1,
        "R7 rate under random grants", refCount - c0, expRefs(cyc - w0));

    // R10: early exit is held to the minimum, then honoured
    pulseEnter();
    while (!inSelfRefresh) @(negedge clk);
    waitCycles(2);
    pulseExit();
    while (inSelfRefresh) @(negedge clk);
    waitCycles(2);
    chk(srCount == 2, "R9 second entry accepted", srCount, 2);
    chk(lastSrLen >= SRMIN && lastSrLen <= SRMIN + 4, "R10 minimum held", lastSrLen, SRMIN);
    waitCycles(SRRP + 20);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule